// File: doc/BRIEF.md
# SPI Controller with Switchable FIFOs

This block moves words between a host and a serial peripheral link. It can act as master or as slave. On every frame the contents of its shift register go out while the remote device's shift register contents come in, so each transfer is a full exchange. A mode input selects 8-bit or 16-bit frames at run time. Bits go out MSB first. The serial clock idles low. Outgoing data changes on the falling clock edge and incoming data is sampled on the rising edge.

The host writes transmit words through a valid/ready stream. A word is accepted on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` drops when the transmit buffer is full, and a word held on the port waits there until space frees up. Received words come out on a second valid/ready stream. `rx_valid` stays high while any word is buffered, and a word is removed on a clock where `rx_ready` is high. The receive side cannot hold off the link: a frame that completes while the receive buffer is full is lost.

With `fifo_en` low, each direction has a single holding register in front of the shifter. With `fifo_en` high, each direction gets 8 bytes of storage: eight entries in 8-bit mode, four entries in 16-bit mode. In FIFO mode the block also reports transmit-empty and receive-full, each with its own maskable interrupt. A receive overflow sets a sticky error bit in either mode. Configuration inputs are expected to change only while no frame is in progress and both buffers are empty.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the block shows the following: `tx_ready`=1, `rx_valid`=0, `ss_n_o`=1, `sck_o`=0, `rx_ovf`=0.
- R2: In master mode (`master`=1) a frame starts by itself whenever transmit data is buffered and no frame is in progress. `ss_n_o` is low exactly while the frame runs, and `sck_o` stays low whenever `ss_n_o` is high. In slave mode `ss_n_o` stays 1 and `sck_o` stays 0.
- R3: Frames are sent MSB first. The output data bit changes only on a falling serial clock edge and stays stable while the clock is high. Input data is sampled on the rising edge.
- R4: Every frame is a full exchange. The word shifted in from the remote side appears on `rx_data` in arrival order.
- R5: `mode16`=1 selects 16-bit frames and `mode16`=0 selects 8-bit frames. In 8-bit mode only `tx_data[7:0]` is sent and `rx_data[15:8]` reads 0.
- R6: With `fifo_en`=0 the transmit side holds one word beyond the one being shifted. While a frame runs and that holding register is occupied, `tx_ready` is 0.
- R7: With `fifo_en`=1 the transmit buffer accepts 8 words in 8-bit mode and 4 words in 16-bit mode before `tx_ready` falls.
- R8: `tx_empty` is 1 only when `fifo_en`=1 and the transmit buffer is empty. `irq_txe` equals `tx_empty` gated by `txe_ie`. Both outputs are 0 when `fifo_en`=0.
- R9: `rx_full` is 1 when `fifo_en`=1 and the receive buffer holds its capacity. `irq_rxf` equals `rx_full` gated by `rxf_ie`.
- R10: A frame that completes while the receive buffer is full is discarded and sets `rx_ovf`. `rx_ovf` stays set until a one-cycle pulse on `ovf_clr`, and it raises no interrupt.
- R11: In slave mode the block loads one transmit word when `ss_n_i` falls and exchanges one frame per selection. It drives 0 bits if no transmit word is buffered. Serial clock edges are ignored while `ss_n_i` is high. If `ss_n_i` rises before a frame is complete, the partial frame is discarded and the word loaded for it is consumed.
- R12: In master mode each half period of `sck_o` lasts `clk_div`+1 cycles of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = master, 0 = slave |
| mode16 | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| fifo_en | input | 1 | Enables 8-byte FIFOs in place of single holding registers |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| rxf_ie | input | 1 | Receive-full interrupt enable |
| ovf_clr | input | 1 | Clears the sticky overflow bit |
| tx_valid | input | 1 | Host offers a transmit word |
| tx_ready | output | 1 | Transmit buffer has space |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | A received word is available |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | 16 | Oldest received word |
| tx_empty | output | 1 | Transmit FIFO empty (FIFO mode only) |
| rx_full | output | 1 | Receive FIFO full (FIFO mode only) |
| rx_ovf | output | 1 | Sticky receive overflow |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rxf | output | 1 | Receive-full interrupt |
| sck_o | output | 1 | Serial clock out (master) |
| ss_n_o | output | 1 | Slave select out, active low (master) |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Slave select in, active low (slave) |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |

## Verification
The bound checker watches several rules on every cycle:
- the serial clock stays low while the master is deselected;
- the master data line stays stable through each high clock phase;
- a slave never drives the clock or select pins;
- the overflow bit is sticky;
- the FIFO flags agree with the stream handshakes.

Only the bench scenarios can show the rest:
- frame content, bit order and the pairing of sent and received words;
- buffer capacities in each width;
- the divider's timing;
- discarding a frame on overflow or on early deselection.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt >= limit);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W     = 16,
  localparam int HW   = W / 2,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode16,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         abort,
  input  logic         rise,
  input  logic         fall,
  input  logic         sdi,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  logic [W-1:0]    sh, nxt;
  logic            smp;
  logic [CNTW-1:0] cnt, nbits;

  assign nbits   = mode16 ? CNTW'(W) : CNTW'(HW);
  assign nxt     = {sh[W-2:0], smp};
  assign done    = busy & fall & (cnt == nbits - CNTW'(1));
  assign rx_word = mode16 ? nxt : {{HW{1'b0}}, nxt[HW-1:0]};
  assign sdo     = mode16 ? sh[W-1] : sh[HW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      smp  <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= load_data;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      if (rise) smp <= sdi;
      if (fall) begin
        sh  <= nxt;
        cnt <= cnt + CNTW'(1);
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int FIFO_BYTES  = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             mode16,
  input  logic             fifo_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             txe_ie,
  input  logic             rxf_ie,
  input  logic             ovf_clr,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [15:0]      tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [15:0]      rx_data,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_ovf,
  output logic             irq_txe,
  output logic             irq_rxf,
  output logic             sck_o,
  output logic             ss_n_o,
  output logic             mosi_o,
  input  logic             miso_i,
  input  logic             sck_i,
  input  logic             ss_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe
);
  localparam int CW = $clog2(FIFO_BYTES + 1);

  // Capacity: one holding slot, or the FIFO bytes as bytes or halfwords
  logic [CW-1:0] limit;
  assign limit = !fifo_en ? CW'(1) : (mode16 ? CW'(FIFO_BYTES / 2) : CW'(FIFO_BYTES));

  // Transmit path
  word_t tx_wdata, txf_rdata, ld_data;
  logic  txf_empty, txf_full, sh_load;
  assign tx_wdata = mode16 ? tx_data : {{BYTE_W{1'b0}}, tx_data[BYTE_W-1:0]};
  assign tx_ready = ~txf_full;
  assign ld_data  = txf_empty ? '0 : txf_rdata;

  spi_fifo #(.DEPTH(FIFO_BYTES), .W(WORD_W)) u_txf (
    .clk(clk), .rst_n(rst_n), .limit(limit),
    .push(tx_valid & tx_ready), .wdata(tx_wdata),
    .pop(sh_load), .rdata(txf_rdata), .empty(txf_empty), .full(txf_full)
  );

  // Receive path
  word_t rx_word;
  logic  rxf_empty, rxf_full, sh_done;
  assign rx_valid = ~rxf_empty;

  spi_fifo #(.DEPTH(FIFO_BYTES), .W(WORD_W)) u_rxf (
    .clk(clk), .rst_n(rst_n), .limit(limit),
    .push(sh_done), .wdata(rx_word),
    .pop(rx_ready), .rdata(rx_data), .empty(rxf_empty), .full(rxf_full)
  );

  // Slave pin synchronizer: {sck, ss_n, mosi}
  logic [2:0] stg [SYNC_STAGES];
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[g] <= 3'b010;
      else if (g == 0) stg[g] <= {sck_i, ss_n_i, mosi_i};
      else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
    end
  end

  logic sck_s, ss_s, mosi_s, sck_d, ss_d;
  assign {sck_s, ss_s, mosi_s} = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      ss_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
    end
  end

  // Master clock divider
  logic             sh_busy, sck_q, tick;
  logic [DIV_W-1:0] div_cnt;
  assign tick = sh_busy & (div_cnt == clk_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sck_q   <= 1'b0;
    end else if (!master || !sh_busy) begin
      div_cnt <= '0;
      sck_q   <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sck_q   <= ~sck_q;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  // Edge and start selection per role
  logic m_start, s_start, s_abort, edge_r, edge_f, sdi, sdo;
  assign m_start = master & ~sh_busy & ~txf_empty;
  assign s_start = ~master & ss_d & ~ss_s;
  assign s_abort = ~master & ss_s & sh_busy;
  assign sh_load = m_start | s_start;
  assign edge_r  = master ? (tick & ~sck_q) : (~ss_s & sck_s & ~sck_d);
  assign edge_f  = master ? (tick & sck_q)  : (~ss_s & ~sck_s & sck_d);
  assign sdi     = master ? miso_i : mosi_s;

  spi_shifter #(.W(WORD_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .mode16(mode16),
    .load(sh_load), .load_data(ld_data), .abort(s_abort),
    .rise(edge_r), .fall(edge_f), .sdi(sdi),
    .sdo(sdo), .busy(sh_busy), .done(sh_done), .rx_word(rx_word)
  );

  // Sticky overflow: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_ovf <= 1'b0;
    else if (sh_done & rxf_full) rx_ovf <= 1'b1;
    else if (ovf_clr)            rx_ovf <= 1'b0;
  end

  assign tx_empty = fifo_en & txf_empty;
  assign rx_full  = fifo_en & rxf_full;
  assign irq_txe  = tx_empty & txe_ie;
  assign irq_rxf  = rx_full & rxf_ie;

  assign sck_o   = sck_q;
  assign ss_n_o  = ~(master & sh_busy);
  assign mosi_o  = master & sh_busy & sdo;
  assign miso_o  = sdo;
  assign miso_oe = ~master & ~ss_s;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic sck_o,
  input logic ss_n_o,
  input logic mosi_o,
  input logic rx_ovf,
  input logic ovf_clr,
  input logic rx_full,
  input logic rx_valid,
  input logic irq_txe,
  input logic tx_ready
);
  AST_SCK_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss_n_o) |-> !sck_o); // R2

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (ss_n_o && !sck_o)); // R2

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (master && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clr) |=> rx_ovf); // R10

  AST_RXFULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_valid); // R9

  AST_TXE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txe |-> tx_ready); // R8
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .sck_o(sck_o), .ss_n_o(ss_n_o),
  .mosi_o(mosi_o), .rx_ovf(rx_ovf), .ovf_clr(ovf_clr), .rx_full(rx_full),
  .rx_valid(rx_valid), .irq_txe(irq_txe), .tx_ready(tx_ready)
);

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;
  localparam int H = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        master = 1'b1, mode16 = 1'b0, fifo_en = 1'b0;
  logic [7:0]  clk_div = 8'd3;
  logic        txe_ie = 1'b1, rxf_ie = 1'b1, ovf_clr = 1'b0;
  logic        tx_valid = 1'b0, rx_ready = 1'b1;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, tx_empty, rx_full, rx_ovf, irq_txe, irq_rxf;
  logic [15:0] rx_data;
  logic        sck_o, ss_n_o, mosi_o, miso_i, miso_o, miso_oe;
  logic        sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int checks = 0, errors = 0;
  logic [15:0] exp_rx[$], exp_mosi[$], rem_q[$];
  logic [15:0] rem_sh = '0, rem_cap = '0;

  always #5 clk = ~clk;

  spi_xcvr u_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .master(master), .mode16(mode16), .fifo_en(fifo_en),
    .clk_div(clk_div), .txe_ie(txe_ie), .rxf_ie(rxf_ie), .ovf_clr(ovf_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
    .irq_txe(irq_txe), .irq_rxf(irq_rxf),
    .sck_o(sck_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Remote slave model for master-mode frames
  assign miso_i = mode16 ? rem_sh[15] : rem_sh[7];
  always @(negedge ss_n_o) if (rst_n === 1'b1 && master) begin
    rem_sh  = (rem_q.size() != 0) ? rem_q.pop_front() : 16'h0;
    rem_cap = '0;
  end
  always @(posedge sck_o) rem_cap = {rem_cap[14:0], mosi_o};
  always @(negedge sck_o) rem_sh = rem_sh << 1;
  always @(posedge ss_n_o) if (rst_n === 1'b1 && master) begin
    logic [15:0] got, e;
    got = mode16 ? rem_cap : {8'h00, rem_cap[7:0]};
    e   = (exp_mosi.size() != 0) ? exp_mosi.pop_front() : 16'hxxxx;
    check(got === e, "R3 mosi frame MSB first", got, e);
  end

  // Receive-side scoreboard monitor
  always @(negedge clk) if (rst_n && rx_valid && rx_ready) begin
    if (exp_rx.size() == 0) check(1'b0, "R4 unexpected rx word", rx_data, 16'h0);
    else begin
      logic [15:0] e;
      e = exp_rx.pop_front();
      check(rx_data === e, "R4 rx word", rx_data, e);
    end
  end

  // Driver: one word through the transmit stream
  task automatic push(input logic [15:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic mxfer(input logic [15:0] send, input logic [15:0] remote);
    exp_mosi.push_back(mode16 ? send : {8'h00, send[7:0]});
    rem_q.push_back(remote);
    exp_rx.push_back(mode16 ? remote : {8'h00, remote[7:0]});
    push(send);
  endtask

  task automatic drain();
    while (exp_rx.size() != 0 || exp_mosi.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Bench acting as master toward the design in slave mode
  task automatic sxfer(input logic [15:0] w, input int nb, output logic [15:0] cap);
    cap = '0;
    ss_n_i = 1'b0;
    for (int b = nb - 1; b >= 0; b--) begin
      mosi_i = w[b];
      repeat (H) @(negedge clk);
      sck_i = 1'b1;
      cap = {cap[14:0], miso_o};
      repeat (H) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (H) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic fill(input logic [15:0] base, output int n);
    n = 0;
    repeat (12) begin
      @(negedge clk);
      if (tx_ready) begin
        tx_valid = 1'b1;
        tx_data  = base + 16'(n);
        n++;
      end else tx_valid = 1'b0;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    finish_up();
  end

  initial begin
    logic [15:0] cap;
    int n, hp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b1, "R1 tx_ready", 16'(tx_ready), 16'h1);
    check(rx_valid === 1'b0, "R1 rx_valid", 16'(rx_valid), 16'h0);
    check(ss_n_o === 1'b1 && sck_o === 1'b0, "R1 pins idle", {ss_n_o, sck_o}, 16'h2);
    check(rx_ovf === 1'b0, "R1 rx_ovf", 16'(rx_ovf), 16'h0);
    check(tx_empty === 1'b0 && irq_txe === 1'b0, "R8 flags off without fifo", 16'(tx_empty), 16'h0);

    // Master, 8-bit, single holding register
    mxfer(16'hFFA5, 16'h003C);
    mxfer(16'h005A, 16'h00C3);
    check(tx_ready === 1'b0, "R6 holding occupied", 16'(tx_ready), 16'h0);
    @(posedge sck_o);
    hp = 0;
    forever begin
      @(negedge clk);
      if (sck_o) hp++; else break;
    end
    check(hp == 4, "R12 half period", 16'(hp), 16'd4);
    check(ss_n_o === 1'b0, "R2 select low during frame", 16'(ss_n_o), 16'h0);
    drain();

    // Master, 16-bit, FIFO mode, fastest divider
    fifo_en = 1'b1; mode16 = 1'b1; clk_div = 8'd0;
    @(negedge clk);
    check(tx_empty === 1'b1 && irq_txe === 1'b1, "R8 empty flag and irq", {tx_empty, irq_txe}, 16'h3);
    mxfer(16'h8001, 16'h1234);
    mxfer(16'hBEEF, 16'hF00D);
    mxfer(16'h0F0F, 16'hA55A);
    mxfer(16'h7FFE, 16'h8000);
    drain();
    check(tx_empty === 1'b1, "R8 empty after drain", 16'(tx_empty), 16'h1);

    // Slave, 8-bit: capacity, then receive fill and overflow
    master = 1'b0; mode16 = 1'b0; rx_ready = 1'b0;
    @(negedge clk);
    check(ss_n_o === 1'b1 && sck_o === 1'b0, "R2 slave drives no clock", {ss_n_o, sck_o}, 16'h2);
    fill(16'h0010, n);
    check(n == 8, "R7 8-bit capacity", 16'(n), 16'd8);
    check(tx_empty === 1'b0, "R8 not empty", 16'(tx_empty), 16'h0);
    for (int i = 0; i < 8; i++) begin
      sxfer(16'h00A0 + 16'(i), 8, cap);
      check(cap === 16'h0010 + 16'(i), "R11 slave miso word", cap, 16'h0010 + 16'(i));
    end
    check(rx_full === 1'b1 && irq_rxf === 1'b1, "R9 rx full and irq", {rx_full, irq_rxf}, 16'h3);
    check(rx_ovf === 1'b0, "R10 no overflow yet", 16'(rx_ovf), 16'h0);
    sxfer(16'h00EE, 8, cap);
    check(cap === 16'h0000, "R11 zeros when tx empty", cap, 16'h0);
    check(rx_ovf === 1'b1, "R10 overflow set", 16'(rx_ovf), 16'h1);
    for (int i = 0; i < 8; i++) exp_rx.push_back(16'h00A0 + 16'(i));
    rx_ready = 1'b1;
    drain();
    check(rx_full === 1'b0, "R9 full clears", 16'(rx_full), 16'h0);
    check(rx_ovf === 1'b1, "R10 overflow sticky", 16'(rx_ovf), 16'h1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    @(negedge clk);
    check(rx_ovf === 1'b0, "R10 overflow cleared", 16'(rx_ovf), 16'h0);

    // Slave: early deselect and clock while deselected
    push(16'h0055);
    sxfer(16'h00FF, 3, cap);
    for (int i = 0; i < 8; i++) begin
      sck_i = ~sck_i;
      repeat (H) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(rx_valid === 1'b0, "R11 partial frame dropped", 16'(rx_valid), 16'h0);
    push(16'h0066);
    exp_rx.push_back(16'h0099);
    sxfer(16'h0099, 8, cap);
    check(cap === 16'h0066, "R11 next word after abort", cap, 16'h0066);
    drain();

    // Slave, 16-bit FIFO capacity and exchange
    mode16 = 1'b1;
    fill(16'hB000, n);
    check(n == 4, "R7 16-bit capacity", 16'(n), 16'd4);
    exp_rx.push_back(16'hC0DE);
    sxfer(16'hC0DE, 16, cap);
    check(cap === 16'hB000, "R5 16-bit slave frame", cap, 16'hB000);
    drain();

    finish_up();
  end
endmodule